// File: doc/BRIEF.md
# LPC-Style Memory Cycle Target

This block is the peripheral end of a low pin count host bus. It sees only a clock, an active-low frame strobe and a 4-bit nibble bus. The host sends the transfer in order: a start nibble, a type/direction nibble, eight address nibbles, and write data if the cycle is a write. The block then decides whether the address falls in one of its two windows. If it does, it takes the bus after the host's two turnaround clocks. It drives sync nibbles for a programmable number of wait states, returns read data as two nibbles, and hands the bus back through its own turnaround clock.

Reads go to a memory port or a register port, chosen by the window that matched. Writes go only to the register port, as a single-cycle strobe with the local address and the assembled byte. Both read ports answer one clock after their enable, as block RAM does. A low frame strobe in the middle of a cycle abandons that cycle and is treated as a possible new start. A synchronous reset or initialise input returns the block to idle.

Top module: `lpc_mem_target`

## Requirements
- R1: While `rst` or `init` is high at a clock edge, the block is idle after that edge: `bus_oe`, `mem_rd_en`, `reg_rd_en` and `reg_wr_en` are all 0.
- R2: A cycle starts only at an edge where `frame_n` is 0 and `bus_in` is 4'b0000. A low frame with any other nibble leaves the block idle, and it never drives the bus for that frame.
- R3: The nibble after the start selects a read (4'b0100) or a write (4'b0110). Any other value ends the cycle with no bus drive and no port strobe.
- R4: The address is eight nibbles, most significant first. A cycle is claimed only when address bits above `ADDR_LO_W` match `MEM_BASE` (reads only) or `REG_BASE` (reads and writes). The low `ADDR_LO_W` bits appear on `loc_addr`, and exactly one read strobe fires per claimed read.
- R5: Counting the start edge as edge 0, the block keeps `bus_oe` low through the two host turnaround clocks. It first drives in the cycle after edge 11 for a read and after edge 13 for a write.
- R6: The sync field is W clocks of 4'b0101 followed by one clock of 4'b0000. W is the value of `wait_cfg` at the edge that takes the last address nibble, and can be 0.
- R7: After the ready sync of a read, the block drives data bits 3:0 and then bits 7:4. The byte comes from `mem_rd_data` or `reg_rd_data`, one clock after the matching enable.
- R8: A write carries two data nibbles, low first, at edges 10 and 11. A claimed write gives exactly one `reg_wr_en` pulse with `loc_addr` and `reg_wr_data`. A write into the memory window is ignored.
- R9: After its last nibble, the block drives 4'b1111 for one clock and then releases the bus.
- R10: A low `frame_n` at any edge inside a cycle aborts it. The bus is released after that edge, and the same edge is evaluated as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high interface reset |
| init | input | 1 | Synchronous active-high initialise, same effect as `rst` |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble bus as seen by the target |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | Target output enable for `bus_out` |
| wait_cfg | input | WAIT_W | Wait-state count used by the next claimed cycle |
| loc_addr | output | ADDR_LO_W | Local address of the claimed cycle |
| mem_rd_en | output | 1 | Memory port read strobe |
| mem_rd_data | input | 8 | Memory port read data, valid one clock after the strobe |
| reg_rd_en | output | 1 | Register port read strobe |
| reg_rd_data | input | 8 | Register port read data, valid one clock after the strobe |
| reg_wr_en | output | 1 | Register port write strobe |
| reg_wr_data | output | 8 | Register port write byte |

## Verification
The bench builds the block with a 12-bit local address. It places the memory window at 32'hFFFF_F000 and the register window at 32'hFED0_0000, so one upper-bit change moves an address out of both windows. `WAIT_W` stays at 3, so every wait count from 0 to 7, including the zero-wait edge case, runs back to back. The read ports return a byte computed from the local address. A wrong nibble order, a wrong address or a wrong port selection therefore shows up directly on the bus.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_WLO,
    ST_WHI,
    ST_HTAR1,
    ST_HTAR2,
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_TTAR
  } tgt_state_e;

  localparam logic [3:0] NIB_START     = 4'b0000;
  localparam logic [3:0] NIB_CT_RD     = 4'b0100;
  localparam logic [3:0] NIB_CT_WR     = 4'b0110;
  localparam logic [3:0] NIB_SYNC_WAIT = 4'b0101;
  localparam logic [3:0] NIB_SYNC_RDY  = 4'b0000;
  localparam logic [3:0] NIB_TAR       = 4'b1111;

endpackage

// File: rtl/lpc_tgt_addr.sv
module lpc_tgt_addr #(
  parameter int              ADDR_W    = 32,
  parameter int              ADDR_LO_W = 16,
  parameter logic [ADDR_W-1:0] MEM_BASE = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'hFFBF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [3:0]        nib_in,
  output logic              last,
  output logic [ADDR_W-1:0] full_addr,
  output logic              hit_mem,
  output logic              hit_reg
);
  localparam int NIBS  = ADDR_W / 4;
  localparam int IDX_W = $clog2(NIBS);

  logic [ADDR_W-5:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  // Address so far plus the nibble on the bus this clock
  assign full_addr = {sh_q, nib_in};
  assign last      = (idx_q == IDX_W'(NIBS - 1));
  assign hit_mem   = (full_addr[ADDR_W-1:ADDR_LO_W] == MEM_BASE[ADDR_W-1:ADDR_LO_W]);
  assign hit_reg   = (full_addr[ADDR_W-1:ADDR_LO_W] == REG_BASE[ADDR_W-1:ADDR_LO_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (clr) begin
      idx_q <= '0;
    end else if (shift_en) begin
      sh_q  <= full_addr[ADDR_W-5:0];
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/lpc_tgt_data.sv
module lpc_tgt_data (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_lo,
  input  logic       cap_hi,
  input  logic       cap_rd,
  input  logic       sel_reg,
  input  logic [3:0] nib_in,
  input  logic [7:0] mem_rdata,
  input  logic [7:0] reg_rdata,
  output logic [7:0] wr_byte,
  output logic [7:0] rd_byte
);
  logic [3:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      wr_byte <= '0;
      rd_byte <= '0;
    end else begin
      if (cap_lo) lo_q    <= nib_in;
      if (cap_hi) wr_byte <= {nib_in, lo_q};
      if (cap_rd) rd_byte <= sel_reg ? reg_rdata : mem_rdata;
    end
  end

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target #(
  parameter int                ADDR_W    = 32,
  parameter int                ADDR_LO_W = 16,
  parameter int                WAIT_W    = 3,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] REG_BASE  = 32'hFFBF_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init,
  input  logic                 frame_n,
  input  logic [3:0]           bus_in,
  output logic [3:0]           bus_out,
  output logic                 bus_oe,
  input  logic [WAIT_W-1:0]    wait_cfg,
  output logic [ADDR_LO_W-1:0] loc_addr,
  output logic                 mem_rd_en,
  input  logic [7:0]           mem_rd_data,
  output logic                 reg_rd_en,
  input  logic [7:0]           reg_rd_data,
  output logic                 reg_wr_en,
  output logic [7:0]           reg_wr_data
);
  import lpc_tgt_pkg::*;

  logic              rst_any;
  tgt_state_e        st_q, nxt_st;
  logic              is_wr_q, nxt_is_wr;
  logic              sel_reg_q;
  logic [WAIT_W-1:0] cnt_q, nxt_cnt;
  logic              nxt_oe;
  logic [3:0]        nxt_out;

  logic              addr_last, hit_mem, hit_reg;
  logic [ADDR_W-1:0] full_addr;
  logic [7:0]        rd_byte;
  logic              addr_done, claim_rd, claim_wr;

  assign rst_any = rst | init;

  lpc_tgt_addr #(
    .ADDR_W   (ADDR_W),
    .ADDR_LO_W(ADDR_LO_W),
    .MEM_BASE (MEM_BASE),
    .REG_BASE (REG_BASE)
  ) u_addr (
    .clk      (clk),
    .rst      (rst_any),
    .clr      (st_q == ST_CTYPE),
    .shift_en (st_q == ST_ADDR && frame_n),
    .nib_in   (bus_in),
    .last     (addr_last),
    .full_addr(full_addr),
    .hit_mem  (hit_mem),
    .hit_reg  (hit_reg)
  );

  lpc_tgt_data u_data (
    .clk      (clk),
    .rst      (rst_any),
    .cap_lo   (st_q == ST_WLO && frame_n),
    .cap_hi   (st_q == ST_WHI && frame_n),
    .cap_rd   (st_q == ST_HTAR2 && frame_n),
    .sel_reg  (sel_reg_q),
    .nib_in   (bus_in),
    .mem_rdata(mem_rd_data),
    .reg_rdata(reg_rd_data),
    .wr_byte  (reg_wr_data),
    .rd_byte  (rd_byte)
  );

  assign addr_done = (st_q == ST_ADDR) && addr_last && frame_n;
  assign claim_rd  = addr_done && !is_wr_q && (hit_mem || hit_reg);
  assign claim_wr  = addr_done && is_wr_q && hit_reg;

  // Next state; a low frame at any edge overrides the sequence
  always_comb begin
    nxt_st    = st_q;
    nxt_is_wr = is_wr_q;
    if (!frame_n) begin
      nxt_st = (bus_in == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  nxt_st = ST_IDLE;
        ST_CTYPE: begin
          if (bus_in == NIB_CT_RD) begin
            nxt_st    = ST_ADDR;
            nxt_is_wr = 1'b0;
          end else if (bus_in == NIB_CT_WR) begin
            nxt_st    = ST_ADDR;
            nxt_is_wr = 1'b1;
          end else begin
            nxt_st = ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (addr_last) begin
            if (claim_wr)      nxt_st = ST_WLO;
            else if (claim_rd) nxt_st = ST_HTAR1;
            else               nxt_st = ST_IDLE;
          end
        end
        ST_WLO:   nxt_st = ST_WHI;
        ST_WHI:   nxt_st = ST_HTAR1;
        ST_HTAR1: nxt_st = ST_HTAR2;
        ST_HTAR2: nxt_st = ST_SYNC;
        ST_SYNC:  if (cnt_q == '0) nxt_st = is_wr_q ? ST_TTAR : ST_DLO;
        ST_DLO:   nxt_st = ST_DHI;
        ST_DHI:   nxt_st = ST_TTAR;
        ST_TTAR:  nxt_st = ST_IDLE;
        default:  nxt_st = ST_IDLE;
      endcase
    end
  end

  // Wait-state counter: loaded when the cycle is claimed
  always_comb begin
    nxt_cnt = cnt_q;
    if (claim_rd || claim_wr)
      nxt_cnt = wait_cfg;
    else if (st_q == ST_SYNC && frame_n && cnt_q != '0)
      nxt_cnt = cnt_q - 1'b1;
  end

  // Bus drive for the cycle after this edge
  always_comb begin
    nxt_oe  = 1'b0;
    nxt_out = 4'b0000;
    case (nxt_st)
      ST_SYNC: begin
        nxt_oe  = 1'b1;
        nxt_out = (nxt_cnt != '0) ? NIB_SYNC_WAIT : NIB_SYNC_RDY;
      end
      ST_DLO: begin
        nxt_oe  = 1'b1;
        nxt_out = rd_byte[3:0];
      end
      ST_DHI: begin
        nxt_oe  = 1'b1;
        nxt_out = rd_byte[7:4];
      end
      ST_TTAR: begin
        nxt_oe  = 1'b1;
        nxt_out = NIB_TAR;
      end
      default: begin
        nxt_oe  = 1'b0;
        nxt_out = 4'b0000;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      st_q      <= ST_IDLE;
      is_wr_q   <= 1'b0;
      sel_reg_q <= 1'b0;
      cnt_q     <= '0;
      bus_oe    <= 1'b0;
      bus_out   <= 4'b0000;
      loc_addr  <= '0;
      mem_rd_en <= 1'b0;
      reg_rd_en <= 1'b0;
      reg_wr_en <= 1'b0;
    end else begin
      st_q      <= nxt_st;
      is_wr_q   <= nxt_is_wr;
      cnt_q     <= nxt_cnt;
      bus_oe    <= nxt_oe;
      bus_out   <= nxt_out;
      mem_rd_en <= claim_rd && hit_mem;
      reg_rd_en <= claim_rd && !hit_mem;
      reg_wr_en <= (st_q == ST_WHI) && frame_n;
      if (claim_rd || claim_wr) begin
        loc_addr  <= full_addr[ADDR_LO_W-1:0];
        sel_reg_q <= !hit_mem;
      end
    end
  end

  // R1: a reset or initialise edge leaves the block quiet
  a_r1_reset_idle: assert property (@(posedge clk)
    (rst || init) |=> (!bus_oe && !mem_rd_en && !reg_rd_en && !reg_wr_en));

  // R10: a low frame strobe frees the bus on the next cycle
  a_r10_abort_release: assert property (@(posedge clk) disable iff (rst || init)
    !frame_n |=> !bus_oe);

  // R9: the target turnaround clock is followed by release
  a_r9_release_after_tar: assert property (@(posedge clk) disable iff (rst || init)
    (st_q == ST_TTAR) |=> !bus_oe);

  // R8: one write strobe per write cycle
  a_r8_single_write: assert property (@(posedge clk) disable iff (rst || init)
    reg_wr_en |=> !reg_wr_en);

  // R4: at most one port strobe at a time
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst || init)
    $onehot0({mem_rd_en, reg_rd_en, reg_wr_en}));

endmodule

// File: tb/lpc_mem_target_tb.sv
module lpc_mem_target_tb;
  localparam int LO_W = 12;
  localparam logic [31:0] MEMB = 32'hFFFF_F000;
  localparam logic [31:0] REGB = 32'hFED0_0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            init = 1'b0;
  logic            frame_n = 1'b1;
  logic [3:0]      bus_in = 4'hF;
  logic [3:0]      bus_out;
  logic            bus_oe;
  logic [2:0]      wait_cfg = 3'd0;
  logic [LO_W-1:0] loc_addr;
  logic            mem_rd_en, reg_rd_en, reg_wr_en;
  logic [7:0]      mem_rd_data = 8'h00;
  logic [7:0]      reg_rd_data = 8'h00;
  logic [7:0]      reg_wr_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int mem_rd_cnt = 0;
  int reg_rd_cnt = 0;
  logic [4:0]  exp_q [int];
  string       exp_tag [int];
  logic [19:0] wr_log [$];

  always #5 clk = ~clk;

  lpc_mem_target #(
    .ADDR_W(32), .ADDR_LO_W(LO_W), .WAIT_W(3), .MEM_BASE(MEMB), .REG_BASE(REGB)
  ) u_dut (
    .clk(clk), .rst(rst), .init(init), .frame_n(frame_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .wait_cfg(wait_cfg), .loc_addr(loc_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data), .reg_rd_en(reg_rd_en),
    .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
  );

  function automatic logic [7:0] fm(input logic [LO_W-1:0] a);
    return 8'((a * 12'd29) + 12'd91);
  endfunction

  function automatic logic [7:0] fr(input logic [LO_W-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hC3;
  endfunction

  // Port models with one clock of read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) begin mem_rd_data <= fm(loc_addr); mem_rd_cnt <= mem_rd_cnt + 1; end
    if (reg_rd_en) begin reg_rd_data <= fr(loc_addr); reg_rd_cnt <= reg_rd_cnt + 1; end
    if (reg_wr_en) wr_log.push_back({loc_addr, reg_wr_data});
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // Reference bus comparison on every clock
  always @(negedge clk) begin
    if (cyc > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.exists(cyc) ? exp_q[cyc] : 5'b0;
      t = exp_tag.exists(cyc) ? exp_tag[cyc] : "R2/R3 idle";
      chk((bus_oe === e[4]) && (!e[4] || bus_out === e[3:0]), t,
          {27'd0, bus_oe, bus_out}, {27'd0, e});
    end
  end

  task automatic step(input logic f, input logic [3:0] n);
    frame_n = f;
    bus_in  = n;
    @(posedge clk);
    #2;
  endtask

  task automatic put(input int key, input int lim, input logic oe, input logic [3:0] v, input string t);
    if (key < lim) begin
      exp_q[key]   = {oe, v};
      exp_tag[key] = t;
    end
  endtask

  // kind: 0 = not claimed, 1 = claimed read, 2 = claimed write
  task automatic xfer(input logic [3:0] ct, input logic [31:0] a, input int w,
                      input logic [7:0] d, input int kind, input int cut);
    int e0, len, lim;
    e0  = cyc + 1;
    len = 15 + w;
    lim = e0 + cut;
    wait_cfg = 3'(w);
    if (kind == 1) begin
      put(e0 + 9, lim, 1'b0, 4'h0, "R5 host turnaround");
      put(e0 + 10, lim, 1'b0, 4'h0, "R5 host turnaround");
      for (int k = 0; k < w; k++) put(e0 + 11 + k, lim, 1'b1, 4'b0101, "R6 short wait");
      put(e0 + 11 + w, lim, 1'b1, 4'b0000, "R6 ready");
      put(e0 + 12 + w, lim, 1'b1, d[3:0], "R7 data low");
      put(e0 + 13 + w, lim, 1'b1, d[7:4], "R7 data high");
      put(e0 + 14 + w, lim, 1'b1, 4'hF, "R9 target turnaround");
      put(e0 + 15 + w, lim, 1'b0, 4'h0, "R9 release");
    end else if (kind == 2) begin
      put(e0 + 11, lim, 1'b0, 4'h0, "R5 host turnaround");
      put(e0 + 12, lim, 1'b0, 4'h0, "R5 host turnaround");
      for (int k = 0; k < w; k++) put(e0 + 13 + k, lim, 1'b1, 4'b0101, "R6 short wait");
      put(e0 + 13 + w, lim, 1'b1, 4'b0000, "R6 ready");
      put(e0 + 14 + w, lim, 1'b1, 4'hF, "R9 target turnaround");
      put(e0 + 15 + w, lim, 1'b0, 4'h0, "R9 release");
    end
    if (cut < len) begin
      exp_q[lim]   = 5'b0;
      exp_tag[lim] = "R10 abort release";
    end
    for (int k = 0; k < len && k < cut; k++) begin
      if (k == 0)                        step(1'b0, 4'h0);
      else if (k == 1)                   step(1'b1, ct);
      else if (k <= 9)                   step(1'b1, a[31 - 4*(k-2) -: 4]);
      else if (ct == 4'h6 && k == 10)    step(1'b1, d[3:0]);
      else if (ct == 4'h6 && k == 11)    step(1'b1, d[7:4]);
      else                               step(1'b1, 4'hF);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    int m0, r0;
    logic [31:0] a;
    logic [7:0]  d;
    #2;
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    // R1: state under reset
    chk(!bus_oe && !mem_rd_en && !reg_rd_en && !reg_wr_en, "R1 reset idle",
        {bus_oe, mem_rd_en, reg_rd_en, reg_wr_en}, 0);
    rst = 1'b0;
    step(1'b1, 4'hF);

    // R4 R6 R7: memory reads with every wait count, back to back
    for (int w = 0; w < 8; w++) begin
      a = MEMB + 32'(w * 12'h1A7);
      m0 = mem_rd_cnt;
      xfer(4'h4, a, w, fm(a[LO_W-1:0]), 1, 99);
      chk(mem_rd_cnt == m0 + 1, "R4 one memory strobe", mem_rd_cnt, m0 + 1);
    end

    // R4 R7: register read
    a = REGB + 32'h0ABC;
    r0 = reg_rd_cnt;
    xfer(4'h4, a, 3, fr(a[LO_W-1:0]), 1, 99);
    chk(reg_rd_cnt == r0 + 1, "R4 one register strobe", reg_rd_cnt, r0 + 1);

    // R8: register writes with every wait count
    for (int w = 0; w < 8; w++) begin
      a = REGB + 32'(w * 12'h213 + 5);
      d = 8'(w * 8'h37 + 8'h1E);
      wr_log.delete();
      xfer(4'h6, a, w, d, 2, 99);
      chk(wr_log.size() == 1, "R8 write count", wr_log.size(), 1);
      if (wr_log.size() == 1)
        chk(wr_log[0] == {a[LO_W-1:0], d}, "R8 write addr/data", wr_log[0], {a[LO_W-1:0], d});
    end

    // R8: write into memory window is ignored
    wr_log.delete();
    xfer(4'h6, MEMB + 32'h10, 2, 8'h5A, 0, 99);
    chk(wr_log.size() == 0, "R8 memory-window write ignored", wr_log.size(), 0);

    // R4: read outside both windows is not claimed
    m0 = mem_rd_cnt; r0 = reg_rd_cnt;
    xfer(4'h4, 32'hFFFE_F010, 2, 8'h00, 0, 99);
    chk(mem_rd_cnt == m0 && reg_rd_cnt == r0, "R4 unclaimed read strobes",
        mem_rd_cnt + reg_rd_cnt, m0 + r0);

    // R3: unknown cycle type
    m0 = mem_rd_cnt;
    wr_log.delete();
    xfer(4'h2, MEMB + 32'h20, 1, 8'h00, 0, 99);
    chk(mem_rd_cnt == m0 && wr_log.size() == 0, "R3 bad type no strobe", mem_rd_cnt, m0);

    // R2: frame low with a non-start nibble, then a valid read
    m0 = mem_rd_cnt;
    step(1'b0, 4'h3);
    step(1'b1, 4'h4);
    step(1'b1, 4'hF);
    chk(mem_rd_cnt == m0, "R2 bad start no strobe", mem_rd_cnt, m0);
    a = MEMB + 32'h0F0F;
    xfer(4'h4, a, 1, fm(a[LO_W-1:0]), 1, 99);

    // R10: abort during sync, then a new read on the same edge
    xfer(4'h4, MEMB + 32'h111, 7, fm(12'h111), 1, 14);
    a = MEMB + 32'h0222;
    xfer(4'h4, a, 2, fm(a[LO_W-1:0]), 1, 99);

    // R10: abort during address, no write lands
    wr_log.delete();
    xfer(4'h6, REGB + 32'h33, 0, 8'hC3, 2, 6);
    a = REGB + 32'h0444;
    xfer(4'h4, a, 0, fr(a[LO_W-1:0]), 1, 99);
    chk(wr_log.size() == 0, "R10 aborted write dropped", wr_log.size(), 0);

    // R1: initialise in the middle of a read
    xfer(4'h4, MEMB + 32'h555, 4, fm(12'h555), 1, 12);
    init = 1'b1;
    step(1'b1, 4'hF);
    init = 1'b0;
    chk(!bus_oe && !mem_rd_en, "R1 init idle", {bus_oe, mem_rd_en}, 0);
    step(1'b1, 4'hF);
    a = MEMB + 32'h0666;
    xfer(4'h4, a, 5, fm(a[LO_W-1:0]), 1, 99);

    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    finish_run();
  end

endmodule